// File: doc/BRIEF.md
# Multi-Mode Link Frame Assembler

This block builds one 120-bit link frame on each frame strobe. The strobe is a clock enable that marks the slow frame rate inside a faster system clock. A frame can carry one of three payload kinds, chosen by a mode input:

- **Protected.** A 4-bit header, two internal-control bits, two external-control bits and 80 user bits, closed by a 32-bit check field. The check field is supplied by an external error-correction encoder.
- **Wide.** The same header and control fields, but with 112 user bits. The top 32 user bits fill the slot that the check field occupies in protected mode, so the lower 80 bits keep the positions they have in protected mode.
- **Line-coded.** Twelve 10-bit code groups, produced by an external line encoder, fill the whole frame. This mode has no header and no protection.

The header is a DC-balanced pattern with two ones and two zeros. It tells a data frame from an idle frame. Wide and line-coded frames are legal only in the upstream direction. When the direction input selects downstream, the block always builds a protected frame, whatever the mode input says.

The frame and the applied mode are registered together on the strobe. A mode change therefore takes effect only at a frame boundary. Between strobes the output frame does not change. The frame is sent most significant bit first, so header bit 3 leaves first as frame bit 119.

Top module: `frame_assembler`

## Requirements
- R1: After reset, `frame_out` holds an idle header (0110) in bits 119:116 with all other bits zero, and `frame_mode_out` reads 00 (protected).
- R2: In protected and wide frames, bits 119:116 carry 0101 when `data_valid` was 1 at the strobe, and 0110 when it was 0; both patterns contain exactly two ones.
- R3: In protected and wide frames, `ic_bits[1:0]` occupy frame bits 115:114 and `ec_bits[1:0]` occupy frame bits 113:112.
- R4: A protected frame carries `user_data[79:0]` in bits 111:32 and `check_bits[31:0]` in bits 31:0.
- R5: A wide frame carries `user_data[79:0]` in bits 111:32 and `user_data[111:80]` in bits 31:0; `check_bits` do not appear.
- R6: A line-coded frame equals `code_groups`. Group k is `code_groups[119-10k -: 10]`, so group 0 leaves first and is followed by no header.
- R7: With `dir_up`=1, `mode_sel` 00 selects protected, 01 wide and 10 line-coded. The value 11 is built as protected. `frame_mode_out` reports the mode that was applied, using the same codes.
- R8: With `dir_up`=0, every frame is protected and `frame_mode_out` reads 00, whatever `mode_sel` holds.
- R9: `frame_out` and `frame_mode_out` change only on a clock edge where `frame_en` is 1. Input changes between strobes, including `mode_sel`, have no effect until the next strobe.
- R10: Inputs that a mode does not place have no effect on its frame. This covers `user_data[111:80]` in protected mode and `data_valid` in line-coded mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_en | input | 1 | Frame strobe; a new frame is captured on edges where it is 1 |
| dir_up | input | 1 | 1 = upstream (all modes allowed), 0 = downstream (protected only) |
| mode_sel | input | 2 | Requested payload mode: 00 protected, 01 wide, 10 line-coded, 11 treated as protected |
| data_valid | input | 1 | Selects the data header (1) or the idle header (0) |
| ic_bits | input | 2 | Internal-control bits |
| ec_bits | input | 2 | External-control bits |
| user_data | input | 112 | User payload; bits 79:0 in protected mode, all bits in wide mode |
| check_bits | input | 32 | Check field from the external encoder |
| code_groups | input | 120 | Twelve 10-bit line-code groups, group 0 in bits 119:110 |
| frame_out | output | 120 | Assembled frame, bit 119 sent first |
| frame_mode_out | output | 2 | Mode applied to the frame now in `frame_out` |

## Verification
The bench builds the block with its default widths: 80 protected data bits, a 32-bit check or extension slot and 10-bit code groups. Because the mode and direction space is small, the bench sweeps every combination of direction, all four mode codes and both header choices. It repeats each combination with several different payload patterns. This covers the reserved mode code, the downstream override and both header values in every frame type. The bench also changes all inputs between strobes to confirm that the output holds. It repeats frames that differ only in unplaced inputs to confirm that those inputs are ignored.

// File: rtl/frame_pkg.sv
package frame_pkg;

  typedef enum logic [1:0] {
    MODE_PROT = 2'b00,
    MODE_WIDE = 2'b01,
    MODE_LINE = 2'b10,
    MODE_RSVD = 2'b11
  } frame_mode_e;

  localparam int HDR_W  = 4;
  localparam int CTRL_W = 2;

  // Both header patterns hold two ones and two zeros (DC balanced).
  localparam logic [HDR_W-1:0] HDR_DATA = 4'b0101;
  localparam logic [HDR_W-1:0] HDR_IDLE = 4'b0110;

endpackage

// File: rtl/frame_mode_select.sv
module frame_mode_select
  import frame_pkg::*;
(
  input  logic        dir_up,
  input  logic [1:0]  mode_sel,
  output frame_mode_e eff_mode
);

  always_comb begin
    eff_mode = MODE_PROT;
    if (dir_up) begin
      case (mode_sel)
        2'b01:   eff_mode = MODE_WIDE;
        2'b10:   eff_mode = MODE_LINE;
        default: eff_mode = MODE_PROT;
      endcase
    end
  end

endmodule

// File: rtl/frame_header_gen.sv
module frame_header_gen
  import frame_pkg::*;
(
  input  logic             data_valid,
  output logic [HDR_W-1:0] header
);

  always_comb begin
    header = data_valid ? HDR_DATA : HDR_IDLE;
  end

endmodule

// File: rtl/frame_field_mux.sv
module frame_field_mux
  import frame_pkg::*;
#(
  parameter int DATA_W = 80,
  parameter int SLOT_W = 32,
  parameter int GRP_W  = 10
) (
  input  frame_mode_e               eff_mode,
  input  logic [HDR_W-1:0]          header,
  input  logic [CTRL_W-1:0]         ic_bits,
  input  logic [CTRL_W-1:0]         ec_bits,
  input  logic [DATA_W+SLOT_W-1:0]  user_data,
  input  logic [SLOT_W-1:0]         check_bits,
  input  logic [HDR_W+2*CTRL_W+DATA_W+SLOT_W-1:0] code_groups,
  output logic [HDR_W+2*CTRL_W+DATA_W+SLOT_W-1:0] frame_nxt
);

  localparam int FRAME_W = HDR_W + 2*CTRL_W + DATA_W + SLOT_W;
  localparam int NGRP    = FRAME_W / GRP_W;

  logic [FRAME_W-1:0] line_frame;
  logic [SLOT_W-1:0]  tail_slot;

  // Line-coded groups, group 0 at the most significant end.
  for (genvar k = 0; k < NGRP; k++) begin : g_grp
    assign line_frame[FRAME_W-1-k*GRP_W -: GRP_W] =
           code_groups[FRAME_W-1-k*GRP_W -: GRP_W];
  end
  if (NGRP*GRP_W < FRAME_W) begin : g_pad
    assign line_frame[FRAME_W-NGRP*GRP_W-1:0] = '0;
  end

  // Wide mode reuses the check slot for the top user bits.
  always_comb begin
    tail_slot = (eff_mode == MODE_WIDE) ? user_data[DATA_W +: SLOT_W]
                                        : check_bits;
  end

  always_comb begin
    if (eff_mode == MODE_LINE) begin
      frame_nxt = line_frame;
    end else begin
      frame_nxt = {header, ic_bits, ec_bits, user_data[DATA_W-1:0], tail_slot};
    end
  end

endmodule

// File: rtl/frame_assembler.sv
module frame_assembler
  import frame_pkg::*;
#(
  parameter int DATA_W = 80,
  parameter int SLOT_W = 32,
  parameter int GRP_W  = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         frame_en,
  input  logic         dir_up,
  input  logic [1:0]   mode_sel,
  input  logic         data_valid,
  input  logic [1:0]   ic_bits,
  input  logic [1:0]   ec_bits,
  input  logic [111:0] user_data,
  input  logic [31:0]  check_bits,
  input  logic [119:0] code_groups,
  output logic [119:0] frame_out,
  output logic [1:0]   frame_mode_out
);

  localparam int FRAME_W = HDR_W + 2*CTRL_W + DATA_W + SLOT_W;
  localparam logic [FRAME_W-1:0] FRAME_RST = {HDR_IDLE, {(FRAME_W-HDR_W){1'b0}}};

  // Reset synchroniser: asserted asynchronously, released on clk.
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  frame_mode_e        eff_mode;
  logic [HDR_W-1:0]   header;
  logic [FRAME_W-1:0] frame_nxt;

  frame_mode_select u_mode (
    .dir_up   (dir_up),
    .mode_sel (mode_sel),
    .eff_mode (eff_mode)
  );

  frame_header_gen u_hdr (
    .data_valid (data_valid),
    .header     (header)
  );

  frame_field_mux #(
    .DATA_W (DATA_W),
    .SLOT_W (SLOT_W),
    .GRP_W  (GRP_W)
  ) u_mux (
    .eff_mode    (eff_mode),
    .header      (header),
    .ic_bits     (ic_bits),
    .ec_bits     (ec_bits),
    .user_data   (user_data),
    .check_bits  (check_bits),
    .code_groups (code_groups),
    .frame_nxt   (frame_nxt)
  );

  // Next-state: capture only on the frame strobe.
  logic [FRAME_W-1:0] frame_d, frame_q;
  frame_mode_e        mode_d, mode_q;

  always_comb begin
    frame_d = frame_q;
    mode_d  = mode_q;
    if (frame_en) begin
      frame_d = frame_nxt;
      mode_d  = eff_mode;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      frame_q <= FRAME_RST;
      mode_q  <= MODE_PROT;
    end else begin
      frame_q <= frame_d;
      mode_q  <= mode_d;
    end
  end

  assign frame_out      = frame_q;
  assign frame_mode_out = mode_q;

endmodule

// File: rtl/frame_assembler_checker.sv
module frame_assembler_checker (
  input logic         clk,
  input logic         rst_n,
  input logic         frame_en,
  input logic         dir_up,
  input logic         data_valid,
  input logic [31:0]  check_bits,
  input logic [119:0] frame_out,
  input logic [1:0]   frame_mode_out
);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_en |=> ($stable(frame_out) && $stable(frame_mode_out)));

  assert_down_prot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_en && !dir_up) |=> (frame_mode_out == 2'b00));

  assert_down_check_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_en && !dir_up) |=> (frame_out[31:0] == $past(check_bits)));

  assert_hdr_kind_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_en |=> ((frame_mode_out == 2'b10) ||
                  (frame_out[119:116] == ($past(data_valid) ? 4'b0101 : 4'b0110))));

  assert_hdr_balance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_mode_out != 2'b10) |-> ($countones(frame_out[119:116]) == 2));

  assert_mode_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_mode_out != 2'b11);

endmodule

bind frame_assembler frame_assembler_checker u_chk (
  .clk            (clk),
  .rst_n          (rst_sync_n),
  .frame_en       (frame_en),
  .dir_up         (dir_up),
  .data_valid     (data_valid),
  .check_bits     (check_bits),
  .frame_out      (frame_out),
  .frame_mode_out (frame_mode_out)
);

// File: tb/frame_assembler_test.sv
module frame_assembler_test;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         frame_en;
  logic         dir_up;
  logic [1:0]   mode_sel;
  logic         data_valid;
  logic [1:0]   ic_bits, ec_bits;
  logic [111:0] user_data;
  logic [31:0]  check_bits;
  logic [119:0] code_groups;
  logic [119:0] frame_out;
  logic [1:0]   frame_mode_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  frame_assembler uut (
    .clk(clk), .rst_n(rst_n), .frame_en(frame_en), .dir_up(dir_up),
    .mode_sel(mode_sel), .data_valid(data_valid), .ic_bits(ic_bits),
    .ec_bits(ec_bits), .user_data(user_data), .check_bits(check_bits),
    .code_groups(code_groups), .frame_out(frame_out),
    .frame_mode_out(frame_mode_out)
  );

  task automatic check120(string tag, logic [119:0] act, logic [119:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check2(string tag, logic [1:0] act, logic [1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_mode(logic up, logic [1:0] m);
    if (!up || m == 2'b11) return 2'b00;
    return m;
  endfunction

  function automatic logic [119:0] exp_frame(logic up, logic [1:0] m, logic dv,
      logic [1:0] ic, logic [1:0] ec, logic [111:0] ud, logic [31:0] ck,
      logic [119:0] cg);
    logic [3:0] h;
    logic [1:0] em;
    h  = dv ? 4'b0101 : 4'b0110;
    em = exp_mode(up, m);
    if (em == 2'b10) return cg;
    if (em == 2'b01) return {h, ic, ec, ud[79:0], ud[111:80]};
    return {h, ic, ec, ud[79:0], ck};
  endfunction

  task automatic load_pattern(int seed);
    user_data   = {4{28'(seed * 32'h9E3779B1 + 32'h1234567)}};
    check_bits  = 32'(seed * 32'h85EBCA6B) ^ 32'hA5A5_0F0F;
    code_groups = {user_data ^ {112{seed[0]}}, 8'(seed * 7 + 3)};
    ic_bits     = 2'(seed);
    ec_bits     = 2'(seed >> 2);
  endtask

  // Drive at negedge, capture at the next posedge, sample at the following negedge.
  task automatic strobe;
    frame_en = 1'b1;
    @(negedge clk);
    frame_en = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; frame_en = 1'b0; dir_up = 1'b0; mode_sel = 2'b00;
    data_valid = 1'b0;
    load_pattern(0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check120("R1 reset frame", frame_out, {4'b0110, 116'b0});
    check2("R1 reset mode", frame_mode_out, 2'b00);

    for (int pat = 1; pat <= 3; pat++) begin
      for (int up = 0; up < 2; up++) begin
        for (int m = 0; m < 4; m++) begin
          for (int dv = 0; dv < 2; dv++) begin
            logic [119:0] ef;
            logic [1:0]   emd;
            load_pattern(pat * 16 + up * 8 + m * 2 + dv);
            dir_up = 1'(up); mode_sel = 2'(m); data_valid = 1'(dv);
            ef  = exp_frame(dir_up, mode_sel, data_valid, ic_bits, ec_bits,
                            user_data, check_bits, code_groups);
            emd = exp_mode(dir_up, mode_sel);
            strobe();
            if (emd == 2'b10)      check120("R6 line-coded frame", frame_out, ef);
            else if (emd == 2'b01) check120("R2 R3 R5 wide frame", frame_out, ef);
            else                   check120("R2 R3 R4 protected frame", frame_out, ef);
            check2(up ? "R7 applied mode" : "R8 downstream mode", frame_mode_out, emd);
            // R9: change everything without a strobe; output must hold.
            load_pattern(pat * 97 + m + 5);
            mode_sel = ~mode_sel; dir_up = ~dir_up; data_valid = ~data_valid;
            repeat (2) @(negedge clk);
            check120("R9 hold between strobes", frame_out, ef);
          end
        end
      end
    end

    // R10: protected mode ignores user_data[111:80]
    begin
      logic [119:0] first;
      dir_up = 1'b1; mode_sel = 2'b00; data_valid = 1'b1; load_pattern(200);
      strobe(); first = frame_out;
      user_data[111:80] = ~user_data[111:80];
      strobe();
      check120("R10 protected ignores upper data", frame_out, first);
      // R10: line-coded ignores data_valid
      mode_sel = 2'b10; data_valid = 1'b0; strobe(); first = frame_out;
      data_valid = 1'b1; strobe();
      check120("R10 line-coded ignores data_valid", frame_out, first);
      check120("R6 line-coded equals groups", frame_out, code_groups);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule